// File: doc/BRIEF.md
# Retentive Word Memory with Split Address Decoder

This block is a small synchronous word memory with a power input, written as a behavioural, synthesizable model. Its contents are not lost when power drops. While power is on, an enabled access either writes the input word into the addressed location or reads that location into a registered output. While power is off, no access takes place. During that time the output is driven from a shadow register that always holds the most recently written word.

The address decoder has two halves. The top address bit decides which half is enabled, and only that half drives a one-hot word select. The other half stays at all zeros, which keeps decoder switching low. The geometry is set by parameters. The intended settings are 8×16, 32×16, 32×32 and 64×32.

Top module: `rmem_core`

## Requirements
- R1: During reset (synchronous, `rst_n` low) the output and the shadow register become zero. The output reads zero on the first cycle after reset.
- R2: A read (`pwr_on`=1, `en`=1, `wr`=0) returns the word held at `addr`. The word appears on `dout` one clock after the read request.
- R3: `dout` holds its value in every cycle that has power but no read: idle cycles, writes, and the cycles after power returns.
- R4: With `en` low, nothing is written, so a later read returns the earlier contents.
- R5: A write (`pwr_on`=1, `en`=1, `wr`=1) changes only the addressed word. Exactly one word select is active per enabled access, and none is active otherwise.
- R6: While `pwr_on` is low, write and read requests are ignored. The array is unchanged and the output is not loaded from the array.
- R7: One clock after `pwr_on` is sampled low, `dout` equals the shadow register. It keeps that value for as long as power stays off.
- R8: Every write also copies its data into the shadow register, so the most recent write is the one retained.
- R9: Reset clears the shadow register but not the array. Words written before the reset can still be read after it.
- R10: The decoder is split at address bit AW-1 into two halves. At most one half is enabled in any cycle, and words whose addresses differ only in that bit do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on | input | 1 | High while supply is present |
| en | input | 1 | Access enable for the decoder |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address, AW = log2(WORDS) |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Registered read or retained data |

## Verification
The bound checker watches several behaviours on every cycle:
- At most one decoder half is enabled, and the word select is one-hot exactly when an access is enabled.
- The output holds whenever there is power but no read.
- During power-off the output matches a model of the last written word.
- The output is zero after reset.

Some behaviours only the bench's directed scenarios can show. These are the read latency and data, the absence of aliasing between the two decoder halves, ignored writes with `en` low or power off, and the survival of array contents across a reset.

// File: rtl/rmem_pkg.sv
// Package: shared access classification for the retentive memory.
// Assumes: callers sample pwr_on/en/wr in the same cycle they classify.
package rmem_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_OFF   = 2'd3
    } acc_e;

    // Map raw control inputs to one access kind; power-off dominates.
    function automatic acc_e classify(input logic pwr, input logic en, input logic wr);
        if (!pwr)    return ACC_OFF;
        else if (!en) return ACC_IDLE;
        else if (wr)  return ACC_WRITE;
        else          return ACC_READ;
    endfunction

endpackage

// File: rtl/rmem_half_decoder.sv
// Half decoder: turns an address into a one-hot select over N outputs.
// Assumes: N is a power of two and LAW = log2(N); all outputs are zero when en is low.
module rmem_half_decoder #(
    parameter int N   = 32,
    parameter int LAW = $clog2(N)
) (
    input  logic           en,
    input  logic [LAW-1:0] addr,
    output logic [N-1:0]   onehot
);

    // One comparator per output, gated by the half enable.
    for (genvar i = 0; i < N; i++) begin : g_out
        assign onehot[i] = en && (addr == LAW'(i));
    end

endmodule

// File: rtl/rmem_split_decoder.sv
// Split decoder: the top address bit enables exactly one of two half decoders.
// Assumes: WORDS is a power of two of at least 4; the outputs are combinational.
module rmem_split_decoder #(
    parameter int WORDS = 64,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [1:0]    half_en,
    output logic [WORDS-1:0] sel
);

    localparam int HALF = WORDS / 2;
    localparam int LAW  = AW - 1;

    logic hi_bit;

    // Upper address bit steers the enable to one half only.
    always_comb begin
        hi_bit     = addr[AW-1];
        half_en[0] = en && !hi_bit;
        half_en[1] = en &&  hi_bit;
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        rmem_half_decoder #(.N(HALF), .LAW(LAW)) u_half (
            .en     (half_en[h]),
            .addr   (addr[LAW-1:0]),
            .onehot (sel[h*HALF +: HALF])
        );
    end

endmodule

// File: rtl/rmem_array.sv
// Word array: writes the selected word and OR-combines the selected word for reads.
// Assumes: sel is one-hot or zero; contents have no reset and survive power loss.
module rmem_array #(
    parameter int WORDS = 64,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             we,
    input  logic [WORDS-1:0] sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // Store the input word when this word is selected for a write.
        always_ff @(posedge clk) begin
            if (we && sel[i]) mem[i] <= din;
        end
    end

    // OR tree over the masked words forms the read path.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < WORDS; i++) begin
            rd_data = rd_data | (sel[i] ? mem[i] : '0);
        end
    end

endmodule

// File: rtl/rmem_retain.sv
// Retention stage: shadow copy of the last write plus the registered output.
// Assumes: acc comes from rmem_pkg::classify; reset is synchronous active-low.
module rmem_retain
    import rmem_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_e             acc,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] shadow_q;

    // Shadow register follows every write; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                shadow_q <= '0;
        else if (acc == ACC_WRITE) shadow_q <= din;
    end

    // Output: shadow while power is off, array data on a read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else begin
            unique case (acc)
                ACC_OFF:  dout <= shadow_q;
                ACC_READ: dout <= rd_data;
                default:  dout <= dout;
            endcase
        end
    end

endmodule

// File: rtl/rmem_core.sv
// Top: retentive word memory with a split decoder and power-off output retention.
// Assumes: WORDS is a power of two of at least 4; wr=1 writes and wr=0 reads.
module rmem_core
    import rmem_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             en,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    acc_e             acc;
    logic             act;
    logic             we;
    logic [1:0]       half_en;
    logic [WORDS-1:0] word_sel;
    logic [WIDTH-1:0] rd_data;

    // Classify the cycle; the decoder only runs while powered and enabled.
    always_comb begin
        acc = classify(pwr_on, en, wr);
        act = (acc == ACC_READ) || (acc == ACC_WRITE);
        we  = (acc == ACC_WRITE);
    end

    rmem_split_decoder #(.WORDS(WORDS), .AW(AW)) u_dec (
        .en      (act),
        .addr    (addr),
        .half_en (half_en),
        .sel     (word_sel)
    );

    rmem_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_arr (
        .clk     (clk),
        .we      (we),
        .sel     (word_sel),
        .din     (din),
        .rd_data (rd_data)
    );

    rmem_retain #(.WIDTH(WIDTH)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .din     (din),
        .rd_data (rd_data),
        .dout    (dout)
    );

endmodule

// File: rtl/rmem_core_chk.sv
// Checker: cycle-by-cycle properties of rmem_core, attached by bind.
// Assumes: half_en and sel are the decoder outputs of the bound instance.
module rmem_core_chk #(
    parameter int WORDS = 64,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_on,
    input logic             en,
    input logic             wr,
    input logic [AW-1:0]    addr,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] dout,
    input logic [1:0]       half_en,
    input logic [WORDS-1:0] sel
);

    logic [WIDTH-1:0] last_wr;

    // Independent model of the most recent written word.
    always_ff @(posedge clk) begin
        if (!rst_n)                   last_wr <= '0;
        else if (pwr_on && en && wr)  last_wr <= din;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));

    assert_output_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && !(en && !wr)) |=> $stable(dout));

    assert_select_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && en) |-> $onehot(sel));

    assert_no_select_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_on && en) |-> (sel == '0));

    assert_off_retains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (dout == last_wr));

    assert_one_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(half_en));

    assert_half_follows_msb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && en) |-> half_en[addr[AW-1]]);

endmodule

bind rmem_core rmem_core_chk #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_on  (pwr_on),
    .en      (en),
    .wr      (wr),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .half_en (half_en),
    .sel     (word_sel)
);

// File: tb/sim_rmem_core.sv
module sim_rmem_core;
    localparam int CLK_P = 10;
    localparam int WORDS = 64;
    localparam int WIDTH = 32;
    localparam int AW    = $clog2(WORDS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_on = 1'b1;
    logic             en = 1'b0;
    logic             wr = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    logic [WIDTH-1:0] shadow_m = '0;

    always #(CLK_P/2) clk = ~clk;

    rmem_core #(.WORDS(WORDS), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .en(en), .wr(wr),
        .addr(addr), .din(din), .dout(dout)
    );

    function automatic logic [WIDTH-1:0] pat(input int a, input int salt);
        return WIDTH'(32'h5A00_0000 ^ (a * 32'h0101_0101) ^ (salt * 32'h0003_0007));
    endfunction

    task automatic chk(input string req, input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        en = 1'b1; wr = 1'b1; addr = AW'(a); din = d;
        if (pwr_on) shadow_m = d;
        @(negedge clk);
        en = 1'b0; wr = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [WIDTH-1:0] q);
        @(negedge clk);
        en = 1'b1; wr = 1'b0; addr = AW'(a);
        @(negedge clk);
        en = 1'b0;
        q = dout;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 output zero after reset", dout, '0);
    endtask

    task automatic t_rw_patterns();
        logic [WIDTH-1:0] q;
        int al[6] = '{0, 1, 17, 31, 32, 63};
        foreach (al[i]) do_write(al[i], pat(al[i], 1));
        foreach (al[i]) begin
            do_read(al[i], q);
            chk("R2 read data next cycle", q, pat(al[i], 1));
        end
    endtask

    task automatic t_no_alias_R10();
        logic [WIDTH-1:0] q;
        do_write(5, pat(5, 2));
        do_write(5 + WORDS/2, pat(5 + WORDS/2, 3));
        do_read(5, q);
        chk("R10 lower half kept", q, pat(5, 2));
        do_read(5 + WORDS/2, q);
        chk("R10 upper half kept", q, pat(5 + WORDS/2, 3));
        do_write(6, pat(6, 4));
        do_read(5, q);
        chk("R5 neighbour unchanged", q, pat(5, 2));
    endtask

    task automatic t_hold();
        logic [WIDTH-1:0] q;
        do_read(17, q);
        repeat (3) @(negedge clk);
        chk("R3 hold on idle", dout, pat(17, 1));
        do_write(40, pat(40, 5));
        chk("R3 hold across write", dout, pat(17, 1));
    endtask

    task automatic t_en_low();
        logic [WIDTH-1:0] q;
        @(negedge clk);
        en = 1'b0; wr = 1'b1; addr = AW'(31); din = ~pat(31, 1);
        @(negedge clk);
        wr = 1'b0;
        do_read(31, q);
        chk("R4 disabled write ignored", q, pat(31, 1));
    endtask

    task automatic t_power_off();
        logic [WIDTH-1:0] q;
        do_write(12, pat(12, 6));
        do_read(0, q);
        @(negedge clk);
        pwr_on = 1'b0;
        @(negedge clk);
        chk("R7 shadow on output", dout, pat(12, 6));
        en = 1'b1; wr = 1'b1; addr = AW'(12); din = ~pat(12, 6);
        @(negedge clk);
        wr = 1'b0; addr = AW'(0);
        @(negedge clk);
        en = 1'b0;
        chk("R6 read while off ignored", dout, pat(12, 6));
        @(negedge clk);
        pwr_on = 1'b1;
        @(negedge clk);
        chk("R3 hold after power return", dout, pat(12, 6));
        do_read(12, q);
        chk("R6 write while off ignored", q, pat(12, 6));
    endtask

    task automatic t_last_write_wins();
        do_write(7, pat(7, 8));
        do_write(50, pat(50, 9));
        @(negedge clk);
        pwr_on = 1'b0;
        @(negedge clk);
        chk("R8 last write retained", dout, pat(50, 9));
        repeat (4) @(negedge clk);
        chk("R7 retained while off", dout, shadow_m);
        pwr_on = 1'b1;
    endtask

    task automatic t_reset_keeps_array();
        logic [WIDTH-1:0] q;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset clears output", dout, '0);
        pwr_on = 1'b0;
        @(negedge clk);
        chk("R9 shadow cleared by reset", dout, '0);
        pwr_on = 1'b1;
        do_read(50, q);
        chk("R9 array survives reset", q, pat(50, 9));
        do_read(63, q);
        chk("R9 array survives reset hi", q, pat(63, 1));
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rw_patterns();
        t_no_alias_R10();
        t_hold();
        t_en_low();
        t_power_off();
        t_last_write_wins();
        t_reset_keeps_array();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule